// File: doc/BRIEF.md
# Serial-Addressed Wiper Code Bank

This block is the digital control core of a multi-channel digital potentiometer. A host writes to it over a three-wire serial link: a serial clock, an active-low select and a data line. While the select is low, each rising edge of the serial clock shifts one data bit into an 11-bit frame register. When the select returns high, the frame is decoded. Its top three bits name a channel and its low eight bits give that channel's new wiper code. Only the named channel's latch changes. The bit that falls off the far end of the frame register is driven on a serial output, so that several devices can share one select and be loaded in a single long transfer.

The three serial inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and the serial clock and the select are then edge-detected, so that every physical edge causes exactly one action. A preset input forces every channel to mid-scale. A shutdown input holds every latch where it is, parks the serial output high and raises a shutdown flag for the analog side. The number of channels is a parameter, normally four or six.

Top module: `wiper_latch_bank`

## Requirements
- R1: After the synchronous active-high reset, every channel code is 0x80, the serial output is 0 and the shutdown flag is 0.
- R2: A frame is 11 bits, sent most significant bit first: bits 10..8 are the channel address and bits 7..0 are the code. On the rising edge of the select, only the addressed channel takes the code.
- R3: When more than 11 bits are clocked within one select-low window, only the last 11 bits are decoded.
- R4: Serial clock edges that arrive while the select is high do not shift the frame register, and the register keeps its contents between frames. A select pulse with no clock edges commits the held frame again.
- R5: An address equal to or greater than CHANNELS changes no channel.
- R6: While preset is high, every channel is loaded with 0x80 on the next clock. Preset takes precedence over a frame commit in the same cycle.
- R7: The serial output shows bit 10 of the frame register, so the bit clocked in 11 edges earlier appears there. Two chained blocks loaded with a 22-bit transfer receive the first 11 bits in the downstream block and the last 11 bits in the first block.
- R8: While shutdown is high, the shutdown flag is 1 one clock later, the serial output is 1, and frames committed during shutdown are dropped. After release, the channels still hold their earlier codes.
- R9: Every code from 0x00 to 0xFF is stored and presented unchanged, including both extremes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous; data is shifted in on its rising edge |
| cs_n_i | input | 1 | Serial select, active low; its rising edge commits the frame |
| sdi_i | input | 1 | Serial data in |
| preset_i | input | 1 | Forces all channels to mid-scale |
| shdn_i | input | 1 | Shutdown request |
| sdo_o | output | 1 | Serial data out for chaining; high during shutdown |
| shdn_o | output | 1 | Registered shutdown flag |
| wiper_o | output | CHANNELS*8 | Channel codes; channel c occupies bits 8c+7..8c |

## Verification
The bound checker watches on every cycle that at most one channel changes in a cycle without preset, that a commit to an unmapped address leaves all codes unchanged, that preset yields mid-scale everywhere, and that shutdown freezes the codes, raises the flag and parks the serial output. The frame format itself cannot be seen by the checker: that bits land in the right field in MSB-first order, that only the last 11 bits count, that clocks with the select high are ignored, and that a 22-bit transfer splits correctly across two chained blocks. These are shown only by the bench's scenarios, which compare the codes against a model of the frames sent.

// File: rtl/wlb_pkg.sv
package wlb_pkg;
  localparam int ADDR_W  = 3;
  localparam int CODE_W  = 8;
  localparam int FRAME_W = ADDR_W + CODE_W;
  localparam logic [CODE_W-1:0] MID_CODE = 8'h80;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    code_t             code;
  } frame_t;
endpackage

// File: rtl/wlb_sync.sv
// Multi-bit two-or-more-flop synchronizer with per-bit reset values.
module wlb_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign level_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/wlb_rise_det.sv
// Rising-edge detector on already synchronized levels.
module wlb_rise_det #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;
  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= level_i;
  end
  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/wlb_frame_shift.sv
// Frame register: shifts MSB-first, far end is the top bit.
module wlb_frame_shift #(
  parameter int FRAME_W = wlb_pkg::FRAME_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               far_o
);
  logic [FRAME_W-1:0] sr_q;
  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (shift_en) sr_q <= {sr_q[FRAME_W-2:0], bit_i};
  end
  assign frame_o = sr_q;
  assign far_o   = sr_q[FRAME_W-1];
endmodule

// File: rtl/wlb_latch_bank.sv
// One register per channel; all channels are visible at once and preset
// touches every entry in one cycle.
module wlb_latch_bank
  import wlb_pkg::*;
#(
  parameter int CHANNELS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       preset_i,
  input  logic                       commit_i,
  input  logic                       hold_i,
  input  frame_t                     frame_i,
  output logic [CHANNELS*CODE_W-1:0] codes_o
);
  logic write_ok;
  assign write_ok = commit_i && !hold_i;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
    code_t lat_q;
    always_ff @(posedge clk) begin
      if (rst || preset_i)
        lat_q <= MID_CODE;
      else if (write_ok && (frame_i.addr == ADDR_W'(ch)))
        lat_q <= frame_i.code;
    end
    assign codes_o[ch*CODE_W +: CODE_W] = lat_q;
  end
endmodule

// File: rtl/wiper_latch_bank.sv
module wiper_latch_bank
  import wlb_pkg::*;
#(
  parameter int CHANNELS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sclk_i,
  input  logic                       cs_n_i,
  input  logic                       sdi_i,
  input  logic                       preset_i,
  input  logic                       shdn_i,
  output logic                       sdo_o,
  output logic                       shdn_o,
  output logic [CHANNELS*CODE_W-1:0] wiper_o
);
  // bit 2: select, bit 1: serial clock, bit 0: data
  logic [2:0] pin_lvl;
  logic [1:0] pin_rise;
  logic       shift_stb;
  logic       commit_stb;
  logic [FRAME_W-1:0] sr_bits;
  logic       far_bit;
  frame_t     frame_w;
  logic [ADDR_W-1:0] cur_addr;

  wlb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .async_i({cs_n_i, sclk_i, sdi_i}),
    .level_o(pin_lvl)
  );

  wlb_rise_det #(.W(2), .RST_VAL(2'b10)) u_rise (
    .clk(clk), .rst(rst),
    .level_i(pin_lvl[2:1]),
    .rise_o(pin_rise)
  );

  assign shift_stb  = pin_rise[0] && !pin_lvl[2];
  assign commit_stb = pin_rise[1];

  wlb_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst),
    .shift_en(shift_stb),
    .bit_i(pin_lvl[0]),
    .frame_o(sr_bits),
    .far_o(far_bit)
  );

  assign frame_w  = frame_t'(sr_bits);
  assign cur_addr = frame_w.addr;

  wlb_latch_bank #(.CHANNELS(CHANNELS)) u_bank (
    .clk(clk), .rst(rst),
    .preset_i(preset_i),
    .commit_i(commit_stb),
    .hold_i(shdn_i),
    .frame_i(frame_w),
    .codes_o(wiper_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_o  <= 1'b0;
      shdn_o <= 1'b0;
    end else begin
      sdo_o  <= shdn_i ? 1'b1 : far_bit;
      shdn_o <= shdn_i;
    end
  end
endmodule

// File: rtl/wlb_checker.sv
module wlb_checker
  import wlb_pkg::*;
#(
  parameter int CHANNELS = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       preset_i,
  input logic                       shdn_i,
  input logic                       commit,
  input logic [ADDR_W-1:0]          frame_addr,
  input logic                       sdo_o,
  input logic                       shdn_o,
  input logic [CHANNELS*CODE_W-1:0] wiper_o
);
  logic [CHANNELS*CODE_W-1:0] prev_w;
  logic [CHANNELS-1:0]        chg;

  always_ff @(posedge clk) prev_w <= wiper_o;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chg
    assign chg[c] = wiper_o[c*CODE_W +: CODE_W] != prev_w[c*CODE_W +: CODE_W];
  end

  // R2: a frame moves at most one channel
  a_r2_single_channel: assert property (@(posedge clk) disable iff (rst)
    !$past(preset_i) |-> $countones(chg) <= 1);

  // R5: unmapped addresses touch nothing
  a_r5_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
    (commit && (32'(frame_addr) >= CHANNELS) && !preset_i) |=> $stable(wiper_o));

  // R6: preset gives mid-scale on every channel
  a_r6_preset_mid: assert property (@(posedge clk) disable iff (rst)
    preset_i |=> (wiper_o == {CHANNELS{MID_CODE}}));

  // R8: shutdown freezes the codes
  a_r8_latch_hold: assert property (@(posedge clk) disable iff (rst)
    (shdn_i && !preset_i) |=> $stable(wiper_o));

  // R8: serial output parked high
  a_r8_sdo_parked: assert property (@(posedge clk) disable iff (rst)
    shdn_i |=> sdo_o);

  // R8: flag follows the request one clock later
  a_r8_flag_follows: assert property (@(posedge clk) disable iff (rst)
    shdn_i |=> shdn_o);

  a_r8_flag_clears: assert property (@(posedge clk) disable iff (rst)
    !shdn_i |=> !shdn_o);
endmodule

bind wiper_latch_bank wlb_checker #(.CHANNELS(CHANNELS)) u_chk (
  .clk(clk), .rst(rst), .preset_i(preset_i), .shdn_i(shdn_i),
  .commit(commit_stb), .frame_addr(cur_addr),
  .sdo_o(sdo_o), .shdn_o(shdn_o), .wiper_o(wiper_o)
);

// File: tb/wiper_latch_bank_tb.sv
`timescale 1ns/1ps
module wiper_latch_bank_tb;
  import wlb_pkg::*;
  localparam int N    = 4;
  localparam int HALF = 6;
  localparam int VW   = N*CODE_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, preset = 1'b0, shdn = 1'b0;
  logic sdo, shdn_flag, sdo2, shdn_flag2;
  logic [VW-1:0] wiper, wiper2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  code_t model [N];
  logic [VW-1:0] exp_q[$];
  string         tag_q[$];

  always #2.5 clk = ~clk;

  wiper_latch_bank #(.CHANNELS(N)) u_dut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdi),
    .preset_i(preset), .shdn_i(shdn), .sdo_o(sdo), .shdn_o(shdn_flag),
    .wiper_o(wiper)
  );

  // downstream block of a chain, fed from the first block's serial output
  wiper_latch_bank #(.CHANNELS(N)) u_next (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdo),
    .preset_i(1'b0), .shdn_i(1'b0), .sdo_o(sdo2), .shdn_o(shdn_flag2),
    .wiper_o(wiper2)
  );

  function automatic logic [VW-1:0] pack_model();
    logic [VW-1:0] v;
    for (int c = 0; c < N; c++) v[c*CODE_W +: CODE_W] = model[c];
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard driver side: push the model state and wait until consumed
  task automatic expect_model(input string req);
    exp_q.push_back(pack_model());
    tag_q.push_back(req);
    wait (exp_q.size() == 0);
  endtask

  // monitor: pops expected code vectors and compares them with the outputs
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [VW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (wiper !== e) begin
          errors++;
          $display("FAIL %s: actual %0h expected %0h", t, wiper, e);
        end
      end
    end
  end

  // clock n bits of word MSB first; optionally check the serial output
  task automatic shift_bits(input logic [31:0] word, input int n, input bit chk_sdo);
    for (int k = 0; k < n; k++) begin
      sdi = word[n-1-k];
      wait_cyc(HALF);
      sclk = 1'b1;
      wait_cyc(HALF);
      sclk = 1'b0;
      wait_cyc(HALF);
      if (chk_sdo && (k + 1) >= FRAME_W)
        check("R7 sdo", 32'(sdo), 32'(word[n-1-(k+1-FRAME_W)]));
    end
  endtask

  task automatic send_word(input logic [31:0] word, input int n, input bit chk_sdo);
    cs_n = 1'b0;
    wait_cyc(HALF);
    shift_bits(word, n, chk_sdo);
    cs_n = 1'b1;
    wait_cyc(8);
  endtask

  task automatic send_frame(input logic [2:0] a, input code_t c);
    send_word(32'({a, c}), FRAME_W, 1'b0);
  endtask

  initial begin
    for (int c = 0; c < N; c++) model[c] = MID_CODE;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);

    // R1 reset state
    expect_model("R1 reset codes");
    check("R1 sdo", 32'(sdo), 32'd0);
    check("R1 shdn flag", 32'(shdn_flag), 32'd0);

    // R2 basic frames
    send_frame(3'd0, 8'h3C); model[0] = 8'h3C; expect_model("R2 ch0");
    send_frame(3'd1, 8'hA5); model[1] = 8'hA5; expect_model("R2 ch1");
    // R9 extremes
    send_frame(3'd3, 8'hFF); model[3] = 8'hFF; expect_model("R9 full code");
    send_frame(3'd2, 8'h00); model[2] = 8'h00; expect_model("R9 zero code");

    // R5 unmapped addresses
    send_frame(3'd5, 8'h11); expect_model("R5 addr 5");
    send_frame(3'd7, 8'h22); expect_model("R5 addr 7");
    send_frame(3'd4, 8'h33); expect_model("R5 addr 4");

    // R3 long frame: three leading bits then {1, 0x5A}
    send_word({18'd0, 3'b101, 3'd1, 8'h5A}, 14, 1'b0);
    model[1] = 8'h5A; expect_model("R3 last 11 bits");

    // R4 clocks with select high: register holds {001,5A}, far bit 0
    sdi = 1'b1;
    for (int k = 0; k < 5; k++) begin
      wait_cyc(HALF); sclk = 1'b1; wait_cyc(HALF); sclk = 1'b0;
    end
    wait_cyc(HALF);
    check("R4 sdo unchanged", 32'(sdo), 32'd0);
    // R6 preset to mid-scale
    preset = 1'b1; wait_cyc(1); preset = 1'b0; wait_cyc(1);
    for (int c = 0; c < N; c++) model[c] = MID_CODE;
    expect_model("R6 preset");
    // R4 empty select pulse recommits held frame
    cs_n = 1'b0; wait_cyc(HALF); cs_n = 1'b1; wait_cyc(8);
    model[1] = 8'h5A; expect_model("R4 held frame recommit");

    // R6 preset beats a commit
    preset = 1'b1;
    send_frame(3'd0, 8'h77);
    for (int c = 0; c < N; c++) model[c] = MID_CODE;
    expect_model("R6 preset over commit");
    preset = 1'b0;
    wait_cyc(2);
    expect_model("R6 after preset release");

    // R8 shutdown
    send_frame(3'd0, 8'h21); model[0] = 8'h21; expect_model("R8 before shutdown");
    shdn = 1'b1; wait_cyc(2);
    check("R8 shdn flag", 32'(shdn_flag), 32'd1);
    check("R8 sdo parked", 32'(sdo), 32'd1);
    send_frame(3'd0, 8'h99);
    check("R8 sdo parked after frame", 32'(sdo), 32'd1);
    expect_model("R8 frame dropped");
    shdn = 1'b0; wait_cyc(2);
    check("R8 flag release", 32'(shdn_flag), 32'd0);
    check("R8 sdo restored", 32'(sdo), 32'd0);
    expect_model("R8 codes retained");

    // R7 chain: first 11 bits for downstream, last 11 for this block
    send_word({10'd0, 3'd2, 8'h6B, 3'd3, 8'h4E}, 2*FRAME_W, 1'b1);
    model[3] = 8'h4E; expect_model("R7 near block");
    check("R7 downstream ch2", 32'(wiper2[2*CODE_W +: CODE_W]), 32'h6B);

    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 150000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    wait_cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule